// File: doc/BRIEF.md
# Multi-Slope Integrating Converter Sequencer

This block runs the digital side of a multi-slope integrating analog-to-digital converter. A conversion walks a fixed ring of eight phases. The block first integrates the input for a fixed time. It then applies a short bias interval and settles while the input sign is sampled from a comparator. After that it runs the integrator down twice: a fast coarse slope and then a slow fine slope. A null-detector pulse ends each run-down. The block drives four analog control lines so that the integrator front end knows which condition to take in each phase.

Two counters measure the run-down. The primary counter counts the coarse run-down. The secondary counter counts the fine run-down, and each time it wraps it adds one to the primary count. When the conversion ends, the block raises a data-ready flag. A processor then reads the 24-bit primary count as three bytes through a decoded chip-select and a two-bit address. A fourth address returns the flag and the captured polarity. Reading the most significant byte clears the flag. The next conversion begins when the external trigger-delay logic reports delay-done. All period lengths and counter widths are parameters.

Top module: `msadc_seq`

## Requirements
- R1: `phase` follows the fixed ring 0 (sync), 1 (signal), 2 (bias), 3 (wait), 4 (coarse run-down), 5 (fine run-down), 6 (end), 7 (idle/reset) and back to 0. Every change of `phase` moves exactly one step along this ring.
- R2: After `rst`, the block is in phase 7 with `data_ready`=0, `polarity`=0, `rd_data`=0, `an_rst`=1, `an_bias_n`=1 and `an_integ`=`an_slow`=0. Phase 7 is held until a cycle with `delay_done`=1, which moves the block to phase 0.
- R3: Phase 1 stays active for SIG_NORM_CYC clock cycles of counting, or SIG_FAST_CYC cycles if `fast_mode` was 1 during phase 0. The block then leaves on the first clock edge after timeout at which `half_tick`=1. With `half_tick` held at 1, phase 1 lasts exactly L+1 cycles, where L is the selected length.
- R4: Phase 2 lasts exactly BIAS_CYC cycles. `an_bias_n` is 0 throughout phases 2 and 3 and is 1 in every other phase.
- R5: Phase 3 lasts one cycle and loads `polarity` from `cmp_pos` (1 = positive input). `cmp_pos` has no effect in any other phase.
- R6: In phase 4 the primary count rises by one per cycle, and a `null_pulse` ends the phase. A `null_pulse` in phases 0 to 3 has no effect.
- R7: In phase 5 `an_slow`=1 and the secondary counter (SEC_W bits) rises by one per cycle. Each time it wraps from all-ones to zero, the primary count rises by one. A `null_pulse` ends the phase. The resulting count is N1 + floor(N2 / 2^SEC_W), where N1 and N2 are the cycles spent in phases 4 and 5.
- R8: Phase 6 lasts one cycle. Leaving it sets `data_ready`, and `an_rst` is 1 only in phase 7. If a clearing read falls in the same cycle as this setting, the setting wins.
- R9: With `cs`=1 at a clock edge, `rd_data` after that edge holds the count byte chosen by `addr`: 0 gives bits 7:0, 1 gives bits 15:8, 2 gives bits 23:16. `addr`=3 gives the status byte {6'b0, polarity, data_ready}.
- R10: A read with `addr`=2 clears `data_ready`. Reads at other addresses leave it unchanged.
- R11: `an_integ` is 1 in phases 0 and 1 only. Phase 0 lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| half_tick | input | 1 | Half-rate master clock strobe; lets the block leave the signal phase after timeout |
| delay_done | input | 1 | Trigger delay has expired; starts a conversion from idle |
| null_pulse | input | 1 | Null-detector pulse; ends a run-down phase |
| cmp_pos | input | 1 | Comparator sign, 1 = positive input |
| fast_mode | input | 1 | Selects the short integration period |
| cs | input | 1 | Decoded processor read select |
| addr | input | 2 | Byte select for reads |
| rd_data | output | 8 | Registered read data |
| data_ready | output | 1 | Result available flag |
| polarity | output | 1 | Captured input sign |
| phase | output | 3 | Current phase code |
| an_integ | output | 1 | Analog front end integrates the input |
| an_bias_n | output | 1 | Bias/settle control, active low |
| an_slow | output | 1 | Fine (slow) run-down select |
| an_rst | output | 1 | Analog idle/reset condition |

## Verification
Two events can land on the same clock edge: setting `data_ready` when the block leaves the end phase, and clearing it through a most-significant-byte read. The bench provokes this by holding `cs` with `addr`=2 during the one-cycle end phase. It then requires `data_ready` to still be 1 afterwards and the read to return the final top byte. The bench also makes a fine-counter wrap coincide with the null pulse that ends phase 5, with N2 = 16, and checks that the carry still reaches the count.

// File: rtl/msadc_pkg.sv
package msadc_pkg;

  typedef enum logic [2:0] {
    PH_SYNC  = 3'd0,
    PH_SIG   = 3'd1,
    PH_BIAS  = 3'd2,
    PH_WAIT  = 3'd3,
    PH_REF1  = 3'd4,
    PH_REF2  = 3'd5,
    PH_END   = 3'd6,
    PH_RESET = 3'd7
  } phase_e;

  localparam int RD_BYTES = 3;
  localparam int BYTE_W   = 8;

endpackage

// File: rtl/msadc_fsm.sv
module msadc_fsm
  import msadc_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   delay_done,
  input  logic   null_pulse,
  input  logic   half_tick,
  input  logic   sig_done,
  input  logic   bias_done,
  input  logic   cmp_pos,
  output phase_e st,
  output logic   an_integ,
  output logic   an_bias_n,
  output logic   an_slow,
  output logic   an_rst,
  output logic   polarity
);

  phase_e nx;

  // Next-phase selection: every exit goes one step along the ring.
  always_comb begin
    nx = st;
    case (st)
      PH_RESET: if (delay_done)             nx = PH_SYNC;
      PH_SYNC:                              nx = PH_SIG;
      PH_SIG:   if (sig_done && half_tick)  nx = PH_BIAS;
      PH_BIAS:  if (bias_done)              nx = PH_WAIT;
      PH_WAIT:                              nx = PH_REF1;
      PH_REF1:  if (null_pulse)             nx = PH_REF2;
      PH_REF2:  if (null_pulse)             nx = PH_END;
      PH_END:                               nx = PH_RESET;
      default:                              nx = PH_RESET;
    endcase
  end

  // Phase and analog lines are registered together so they stay aligned.
  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= PH_RESET;
      an_integ  <= 1'b0;
      an_bias_n <= 1'b1;
      an_slow   <= 1'b0;
      an_rst    <= 1'b1;
      polarity  <= 1'b0;
    end else begin
      st        <= nx;
      an_integ  <= (nx == PH_SYNC) || (nx == PH_SIG);
      an_bias_n <= !((nx == PH_BIAS) || (nx == PH_WAIT));
      an_slow   <= (nx == PH_REF2);
      an_rst    <= (nx == PH_RESET);
      if (st == PH_WAIT) polarity <= cmp_pos;
    end
  end

endmodule

// File: rtl/msadc_ctr.sv
module msadc_ctr
  import msadc_pkg::*;
#(
  parameter int PRI_W        = 24,
  parameter int SEC_W        = 8,
  parameter int SIG_NORM_CYC = 20000,
  parameter int SIG_FAST_CYC = 2500,
  parameter int BIAS_CYC     = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  phase_e           st,
  input  logic             fast_mode,
  output logic [PRI_W-1:0] pri,
  output logic             sig_done,
  output logic             bias_done
);

  localparam logic [PRI_W-1:0] NORM_LAST = PRI_W'(SIG_NORM_CYC - 1);
  localparam logic [PRI_W-1:0] FAST_LAST = PRI_W'(SIG_FAST_CYC - 1);
  localparam logic [SEC_W-1:0] BIAS_LAST = SEC_W'(BIAS_CYC - 1);

  logic [SEC_W-1:0] sec;
  logic             tmo;
  logic             mode_q;
  logic [PRI_W-1:0] sig_last;

  assign sig_last  = mode_q ? FAST_LAST : NORM_LAST;
  assign sig_done  = tmo;
  assign bias_done = (st == PH_BIAS) && (sec == BIAS_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      pri    <= '0;
      sec    <= '0;
      tmo    <= 1'b0;
      mode_q <= 1'b0;
    end else begin
      case (st)
        PH_SYNC: begin
          pri    <= '0;
          sec    <= '0;
          tmo    <= 1'b0;
          mode_q <= fast_mode;
        end
        PH_SIG: begin
          if (!tmo) begin
            pri <= pri + 1'b1;
            if (pri == sig_last) tmo <= 1'b1;
          end
        end
        PH_BIAS: sec <= sec + 1'b1;
        PH_WAIT: begin
          pri <= '0;
          sec <= '0;
        end
        PH_REF1: pri <= pri + 1'b1;
        PH_REF2: begin
          sec <= sec + 1'b1;
          if (&sec) pri <= pri + 1'b1;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/msadc_rdport.sv
module msadc_rdport
  import msadc_pkg::*;
#(
  parameter int PRI_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs,
  input  logic [1:0]       addr,
  input  logic [PRI_W-1:0] cnt,
  input  logic             polarity,
  input  logic             set_ready,
  output logic [7:0]       rd_data,
  output logic             data_ready
);

  localparam int PAD_W = RD_BYTES * BYTE_W;

  logic [PAD_W-1:0]  padded;
  logic [BYTE_W-1:0] lane [RD_BYTES];
  logic [BYTE_W-1:0] sel;

  generate
    if (PRI_W >= PAD_W) begin : g_trunc
      assign padded = cnt[PAD_W-1:0];
    end else begin : g_ext
      assign padded = {{(PAD_W - PRI_W){1'b0}}, cnt};
    end
    for (genvar g = 0; g < RD_BYTES; g++) begin : g_lane
      assign lane[g] = padded[g*BYTE_W +: BYTE_W];
    end
  endgenerate

  always_comb begin
    case (addr)
      2'd0:    sel = lane[0];
      2'd1:    sel = lane[1];
      2'd2:    sel = lane[2];
      default: sel = {6'b0, polarity, data_ready};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data    <= '0;
      data_ready <= 1'b0;
    end else begin
      if (cs) rd_data <= sel;
      if (set_ready)                  data_ready <= 1'b1;
      else if (cs && addr == 2'd2)    data_ready <= 1'b0;
    end
  end

endmodule

// File: rtl/msadc_seq.sv
module msadc_seq
  import msadc_pkg::*;
#(
  parameter int PRI_W        = 24,
  parameter int SEC_W        = 8,
  parameter int SIG_NORM_CYC = 20000,
  parameter int SIG_FAST_CYC = 2500,
  parameter int BIAS_CYC     = 20
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       half_tick,
  input  logic       delay_done,
  input  logic       null_pulse,
  input  logic       cmp_pos,
  input  logic       fast_mode,
  input  logic       cs,
  input  logic [1:0] addr,
  output logic [7:0] rd_data,
  output logic       data_ready,
  output logic       polarity,
  output logic [2:0] phase,
  output logic       an_integ,
  output logic       an_bias_n,
  output logic       an_slow,
  output logic       an_rst
);

  phase_e           st;
  logic             sig_done;
  logic             bias_done;
  logic [PRI_W-1:0] pri;

  assign phase = st;

  msadc_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .delay_done (delay_done),
    .null_pulse (null_pulse),
    .half_tick  (half_tick),
    .sig_done   (sig_done),
    .bias_done  (bias_done),
    .cmp_pos    (cmp_pos),
    .st         (st),
    .an_integ   (an_integ),
    .an_bias_n  (an_bias_n),
    .an_slow    (an_slow),
    .an_rst     (an_rst),
    .polarity   (polarity)
  );

  msadc_ctr #(
    .PRI_W        (PRI_W),
    .SEC_W        (SEC_W),
    .SIG_NORM_CYC (SIG_NORM_CYC),
    .SIG_FAST_CYC (SIG_FAST_CYC),
    .BIAS_CYC     (BIAS_CYC)
  ) u_ctr (
    .clk       (clk),
    .rst       (rst),
    .st        (st),
    .fast_mode (fast_mode),
    .pri       (pri),
    .sig_done  (sig_done),
    .bias_done (bias_done)
  );

  msadc_rdport #(
    .PRI_W (PRI_W)
  ) u_rd (
    .clk        (clk),
    .rst        (rst),
    .cs         (cs),
    .addr       (addr),
    .cnt        (pri),
    .polarity   (polarity),
    .set_ready  (st == PH_END),
    .rd_data    (rd_data),
    .data_ready (data_ready)
  );

endmodule

// File: rtl/msadc_seq_chk.sv
module msadc_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       half_tick,
  input logic       delay_done,
  input logic       cs,
  input logic [1:0] addr,
  input logic [2:0] phase,
  input logic       data_ready,
  input logic       polarity,
  input logic       an_bias_n
);

  // R1
  phase_ring_chk: assert property (@(posedge clk) disable iff (rst)
    (phase != $past(phase)) |-> (phase == $past(phase) + 3'd1));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == 3'd7 && !delay_done) |=> (phase == 3'd7));

  // R3
  sig_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == 3'd1 && !half_tick) |=> (phase == 3'd1));

  // R4
  bias_line_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == 3'd2 || phase == 3'd3) |-> !an_bias_n);

  // R5
  pol_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (phase != 3'd3) |=> $stable(polarity));

  // R8
  ready_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(data_ready) |-> (phase == 3'd7));

  // R10
  ready_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (cs && addr == 2'd2 && phase != 3'd6) |=> !data_ready);

endmodule

bind msadc_seq msadc_seq_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .half_tick  (half_tick),
  .delay_done (delay_done),
  .cs         (cs),
  .addr       (addr),
  .phase      (phase),
  .data_ready (data_ready),
  .polarity   (polarity),
  .an_bias_n  (an_bias_n)
);

// File: tb/tb_msadc_seq.sv
`timescale 1ns/1ps
module tb_msadc_seq;

  localparam int SEC_W = 4;
  localparam int NORM  = 40;
  localparam int FAST  = 5;
  localparam int BIAS  = 3;

  typedef struct packed {
    logic        fast;
    logic        pol;
    logic [15:0] n1;
    logic [15:0] n2;
    logic [23:0] exp;
  } vec_t;

  // count = n1 + floor(n2 / 16)
  localparam vec_t VEC [0:3] = '{
    '{1'b0, 1'b1, 16'd5,   16'd3,  24'd5},
    '{1'b1, 1'b0, 16'd20,  16'd16, 24'd21},
    '{1'b0, 1'b1, 16'd1,   16'd40, 24'd3},
    '{1'b1, 1'b1, 16'd300, 16'd17, 24'd301}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic half_tick = 1'b1, delay_done = 1'b0, null_pulse = 1'b0;
  logic cmp_pos = 1'b0, fast_mode = 1'b0, cs = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] rd_data;
  logic data_ready, polarity, an_integ, an_bias_n, an_slow, an_rst;
  logic [2:0] phase;

  int total = 0;
  int fails = 0;
  int order_bad = 0;
  logic [2:0] prev_ph = 3'd7;

  always #2.5 clk = ~clk;

  msadc_seq #(
    .PRI_W(24), .SEC_W(SEC_W), .SIG_NORM_CYC(NORM),
    .SIG_FAST_CYC(FAST), .BIAS_CYC(BIAS)
  ) dut (
    .clk(clk), .rst(rst), .half_tick(half_tick), .delay_done(delay_done),
    .null_pulse(null_pulse), .cmp_pos(cmp_pos), .fast_mode(fast_mode),
    .cs(cs), .addr(addr), .rd_data(rd_data), .data_ready(data_ready),
    .polarity(polarity), .phase(phase), .an_integ(an_integ),
    .an_bias_n(an_bias_n), .an_slow(an_slow), .an_rst(an_rst)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  // R1 ring monitor
  always @(negedge clk) begin
    if (rst) prev_ph = 3'd7;
    else begin
      if (phase != prev_ph && phase != prev_ph + 3'd1) order_bad++;
      prev_ph = phase;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    cs = 1'b1;
    addr = a;
    @(negedge clk);
    cs = 1'b0;
    d = rd_data;
  endtask

  task automatic conv(input vec_t v, input bit hold_tick, input bit rd_end);
    int cnt;
    int lim;
    logic [7:0] d;
    lim = v.fast ? FAST : NORM;
    fast_mode = v.fast;
    cmp_pos = v.pol;
    delay_done = 1'b1;
    @(negedge clk);
    delay_done = 1'b0;
    chk(phase == 3'd0 && an_integ, "R11 sync phase integ", phase, 0);
    if (hold_tick) half_tick = 1'b0;
    @(negedge clk);
    chk(phase == 3'd1 && an_integ, "R11 signal phase integ", phase, 1);
    if (hold_tick) begin
      repeat (lim + 4) @(negedge clk);
      chk(phase == 3'd1, "R3 held without half_tick", phase, 1);
      half_tick = 1'b1;
      @(negedge clk);
      chk(phase == 3'd2, "R3 leaves on half_tick", phase, 2);
    end else begin
      cnt = 0;
      while (phase == 3'd1 && cnt < 1000) begin
        cnt++;
        null_pulse = (cnt == 1);   // R6: ignored in signal phase
        @(negedge clk);
      end
      null_pulse = 1'b0;
      chk(cnt == lim + 1, "R3 R6 signal length", cnt, lim + 1);
    end
    cnt = 0;
    while (phase == 3'd2 && cnt < 1000) begin
      if (an_bias_n) cnt += 1000;
      cnt++;
      @(negedge clk);
    end
    chk(cnt == BIAS, "R4 bias length with line low", cnt, BIAS);
    chk(phase == 3'd3 && !an_bias_n, "R4 wait line low", phase, 3);
    @(negedge clk);
    cmp_pos = ~v.pol;               // R5: ignored from here on
    chk(phase == 3'd4, "R1 coarse run-down", phase, 4);
    repeat (int'(v.n1) - 1) @(negedge clk);
    null_pulse = 1'b1;
    @(negedge clk);
    null_pulse = 1'b0;
    chk(phase == 3'd5 && an_slow, "R7 fine run-down slow", phase, 5);
    repeat (int'(v.n2) - 1) @(negedge clk);
    null_pulse = 1'b1;
    @(negedge clk);
    null_pulse = 1'b0;
    chk(phase == 3'd6, "R8 end phase", phase, 6);
    if (rd_end) begin cs = 1'b1; addr = 2'd2; end
    @(negedge clk);
    cs = 1'b0;
    chk(phase == 3'd7 && an_rst, "R8 idle after end", phase, 7);
    chk(data_ready == 1'b1, "R8 ready set wins", data_ready, 1);
    if (rd_end)
      chk(rd_data == v.exp[23:16], "R9 top byte at end", rd_data, v.exp[23:16]);
    chk(polarity == v.pol, "R5 polarity capture", polarity, v.pol);
    rd(2'd0, d);
    chk(d == v.exp[7:0], "R7 R9 byte0", d, v.exp[7:0]);
    rd(2'd1, d);
    chk(d == v.exp[15:8], "R9 byte1", d, v.exp[15:8]);
    rd(2'd3, d);
    chk(d == {6'b0, v.pol, 1'b1}, "R9 R10 status ready kept", d, {6'b0, v.pol, 1'b1});
    rd(2'd2, d);
    chk(d == v.exp[23:16], "R9 byte2", d, v.exp[23:16]);
    chk(data_ready == 1'b0, "R10 cleared by byte2", data_ready, 0);
    chk(order_bad == 0, "R1 ring order", order_bad, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(phase == 3'd7, "R2 reset phase", phase, 7);
    chk(data_ready == 1'b0 && polarity == 1'b0, "R2 reset flags", data_ready, 0);
    chk(rd_data == 8'd0, "R2 reset rd_data", rd_data, 0);
    chk(an_rst && an_bias_n && !an_integ && !an_slow, "R2 reset lines",
        {an_rst, an_bias_n, an_integ, an_slow}, 4'b1100);
    // R2 idle hold, with null and sign activity that must do nothing
    null_pulse = 1'b1;
    cmp_pos = 1'b1;
    repeat (10) @(negedge clk);
    null_pulse = 1'b0;
    chk(phase == 3'd7, "R2 idle waits for delay_done", phase, 7);
    chk(polarity == 1'b0, "R5 sign ignored in idle", polarity, 0);
    for (int i = 0; i < 4; i++) conv(VEC[i], 1'b0, 1'b0);
    conv('{1'b1, 1'b0, 16'd7, 16'd2, 24'd7}, 1'b1, 1'b1);
    summary();
  end

endmodule